// File: doc/BRIEF.md
# Single-Data-Rate SDRAM Controller with Power-Up Sequencing and Auto-Refresh

This block sits between a simple word-wide host port and one 16-bit single-data-rate SDRAM. After reset it holds the memory in NOP for a programmable power-up pause. It then issues a fixed start-up sequence: one all-bank precharge, a programmable number of auto-refresh commands (eight by default) and one mode-register load. Only after that does it open the host port.

In normal operation each host request is served as a closed-page access. The controller opens the row, issues one single-word READ or WRITE without auto-precharge, and closes the page with an all-bank precharge once the active-time and write-recovery minima are met. A free-running interval timer raises a refresh request. The request is taken at the next idle point, ahead of any new host request, as an all-bank precharge followed by AUTO REFRESH. Every gap between commands is a cycle-count parameter.

The state machine names its states for the phase they run:

- Start-up states: PAUSE, IPRE/IPRE_W, IREF/IREF_W and IMRS/IMRS_W.
- Access states: IDLE, ACT/ACT_W, RW/RW_W and PRE/PRE_W.
- Refresh states: RPRE/RPRE_W and REF/REF_W.

Each command state lasts one cycle and loads the gap counter. Its _W partner waits for that counter to reach zero. The transitions run as follows:

- PAUSE → IPRE → IREF, with IREF repeated until all start-up refreshes are issued.
- IREF → IMRS → IDLE.
- IDLE → ACT when a request is accepted.
- ACT → RW → PRE → IDLE.
- IDLE → RPRE when a refresh is pending, then RPRE → REF → IDLE.

Top module: `sdram_ctl`

## Requirements
- R1: From reset until at least INIT_PAUSE cycles after reset release, only NOP (0111) is driven, and host_ready and host_rvalid stay low.
- R2: The first commands after the pause are, in order, one PRECHARGE with A10 high, exactly eight AUTO REFRESH and one LOAD MODE. No other command precedes normal operation, and host_ready stays low until the LOAD MODE completes.
- R3: LOAD MODE is driven with bank 0 and address 0x230: burst length 1 (A[2:0]=000), sequential (A3=0), CAS latency 3 (A[6:4]=011), single-location writes (A9=1).
- R4: These command gaps are never shorter than their minima: ACTIVE to READ/WRITE 5, ACTIVE to PRECHARGE 9, WRITE to PRECHARGE 5, PRECHARGE to ACTIVE or REFRESH 5, ACTIVE to ACTIVE and REFRESH to any command 13, LOAD MODE to the next command 2. ACTIVE is always followed by a NOP cycle.
- R5: Read data is taken from sd_dq_in at the third clock edge after the edge that registers READ. It is presented on host_rdata with host_rvalid high for exactly the one following cycle.
- R6: After start-up, a refresh request is raised every REF_INTERVAL cycles (2344 by default). It is served after the current access as PRECHARGE (A10 high) then AUTO REFRESH with all banks closed.
- R7: The host word address is split as column = addr[7:0], row = addr[18:8], bank = addr[19]. ACTIVE drives the row on sd_a and the bank on sd_ba. READ/WRITE drive the column on sd_a[7:0] with A10 low.
- R8: host_ready is high only when the controller is idle with no refresh pending. A request is accepted when host_req and host_ready are both high at a clock edge, and the next cycle carries ACTIVE.
- R9: sd_dq_oe is high exactly in the cycles that carry WRITE, and sd_dq_out then equals the accepted write data.
- R10: Commands are encoded on {cs_n,ras_n,cas_n,we_n} as NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001 and LOAD MODE 0000. Every access ends with a PRECHARGE with A10 high, so ACTIVE never targets an open bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared with the SDRAM |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W (20) | Word address {bank,row,column} |
| host_wdata | input | DATA_W (16) | Write data |
| host_ready | output | 1 | Controller can accept a request this cycle |
| host_rdata | output | DATA_W (16) | Read data |
| host_rvalid | output | 1 | host_rdata valid this cycle |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W (1) | Bank address |
| sd_a | output | ROW_W (11) | Multiplexed address |
| sd_dq_in | input | DATA_W (16) | Data from the memory |
| sd_dq_out | output | DATA_W (16) | Data to the memory |
| sd_dq_oe | output | 1 | Drive enable for sd_dq_out |

## Verification
A wrong state or a miscounted gap shows up at the command pins in the same cycle. It appears as a command out of the start-up order, a gap below its minimum, an ACTIVE to an open bank, or a REFRESH with a bank still open, and the behavioural memory model flags each of these on the cycle it occurs. A broken address split or data path is seen at the next ACTIVE, at the next READ/WRITE, or at the read-back four cycles after READ, where host_rdata disagrees with the last value written to that word. A refresh timer that is stalled or runs at the wrong rate shows up as a refresh gap outside the expected window within one interval.

// File: rtl/sdram_ctl_pkg.sv
package sdram_ctl_pkg;

    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } cmd_e;

    typedef enum logic [4:0] {
        S_PAUSE,
        S_IPRE,
        S_IPRE_W,
        S_IREF,
        S_IREF_W,
        S_IMRS,
        S_IMRS_W,
        S_IDLE,
        S_ACT,
        S_ACT_W,
        S_RW,
        S_RW_W,
        S_PRE,
        S_PRE_W,
        S_RPRE,
        S_RPRE_W,
        S_REF,
        S_REF_W
    } state_e;

    function automatic int imax(int x, int y);
        return (x > y) ? x : y;
    endfunction

endpackage

// File: rtl/sdram_ctl_wait.sv
module sdram_ctl_wait #(
    parameter int W       = 16,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         done
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= W'(RST_VAL);
        end else if (load) begin
            cnt <= val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/sdram_ctl_refresh.sv
module sdram_ctl_refresh #(
    parameter int INTERVAL = 2344
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic ack,
    output logic pend
);

    localparam int W = $clog2(INTERVAL + 1);

    logic [W-1:0] cnt;
    logic         fire;

    assign fire = en && (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= W'(INTERVAL - 1);
        end else if (!en || fire) begin
            cnt <= W'(INTERVAL - 1);
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (fire) begin
            pend <= 1'b1;
        end else if (ack) begin
            pend <= 1'b0;
        end
    end

endmodule

// File: rtl/sdram_ctl.sv
module sdram_ctl
    import sdram_ctl_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int COL_W        = 8,
    parameter int ROW_W        = 11,
    parameter int BANK_W       = 1,
    parameter int CAS_LAT      = 3,
    parameter int T_RCD        = 5,
    parameter int T_RP         = 5,
    parameter int T_RAS        = 9,
    parameter int T_RC         = 13,
    parameter int T_WR         = 5,
    parameter int T_MRD        = 2,
    parameter int INIT_PAUSE   = 30000,
    parameter int INIT_REFS    = 8,
    parameter int REF_INTERVAL = 2344,
    localparam int ADDR_W      = COL_W + ROW_W + BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ROW_W-1:0]  sd_a,
    input  logic [DATA_W-1:0] sd_dq_in,
    output logic [DATA_W-1:0] sd_dq_out,
    output logic              sd_dq_oe
);

    localparam int AP_BIT    = 10;
    localparam int RD_TO_PRE = imax(T_RAS - T_RCD, 2);
    localparam int WR_TO_PRE = imax(RD_TO_PRE, T_WR);
    localparam int PRE_GAP   = imax(imax(T_RP, T_RC - T_RCD - RD_TO_PRE), 2);
    localparam int MAXT      = T_RCD + T_RP + T_RAS + T_RC + T_WR + T_MRD;
    localparam int TW        = $clog2(INIT_PAUSE + MAXT + 1);
    localparam int RCW       = $clog2(INIT_REFS + 1);
    localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'((1 << 9) | (CAS_LAT << 4));

    state_e              state, state_nx;
    cmd_e                cmd;
    logic                tm_load, tm_done;
    logic [TW-1:0]       tm_val;
    logic                ref_pend, ref_ack, accept, init_done;
    logic [RCW-1:0]      ref_cnt;
    logic                we_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [CAS_LAT-1:0]  rd_pipe;
    logic                issue_rd;

    wire [COL_W-1:0]  col_q  = addr_q[COL_W-1:0];
    wire [ROW_W-1:0]  row_q  = addr_q[COL_W +: ROW_W];
    wire [BANK_W-1:0] bank_q = addr_q[COL_W+ROW_W +: BANK_W];

    sdram_ctl_wait #(
        .W       (TW),
        .RST_VAL (INIT_PAUSE - 1)
    ) u_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tm_load),
        .val   (tm_val),
        .done  (tm_done)
    );

    sdram_ctl_refresh #(
        .INTERVAL (REF_INTERVAL)
    ) u_refresh (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (init_done),
        .ack   (ref_ack),
        .pend  (ref_pend)
    );

    assign host_ready = (state == S_IDLE) && !ref_pend;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_PAUSE;
        end else begin
            state <= state_nx;
        end
    end

    // next state and gap counter control
    always_comb begin
        state_nx = state;
        tm_load  = 1'b0;
        tm_val   = '0;
        ref_ack  = 1'b0;
        accept   = 1'b0;
        unique case (state)
            S_PAUSE:  if (tm_done) state_nx = S_IPRE;
            S_IPRE: begin
                tm_load  = 1'b1;
                tm_val   = TW'(T_RP - 2);
                state_nx = S_IPRE_W;
            end
            S_IPRE_W: if (tm_done) state_nx = S_IREF;
            S_IREF: begin
                tm_load  = 1'b1;
                tm_val   = TW'(T_RC - 2);
                state_nx = S_IREF_W;
            end
            S_IREF_W: if (tm_done) state_nx = (ref_cnt == RCW'(INIT_REFS)) ? S_IMRS : S_IREF;
            S_IMRS: begin
                tm_load  = 1'b1;
                tm_val   = TW'(T_MRD - 2);
                state_nx = S_IMRS_W;
            end
            S_IMRS_W: if (tm_done) state_nx = S_IDLE;
            S_IDLE: begin
                if (ref_pend) begin
                    state_nx = S_RPRE;
                end else if (host_req) begin
                    accept   = 1'b1;
                    state_nx = S_ACT;
                end
            end
            S_ACT: begin
                tm_load  = 1'b1;
                tm_val   = TW'(T_RCD - 2);
                state_nx = S_ACT_W;
            end
            S_ACT_W:  if (tm_done) state_nx = S_RW;
            S_RW: begin
                tm_load  = 1'b1;
                tm_val   = we_q ? TW'(WR_TO_PRE - 2) : TW'(RD_TO_PRE - 2);
                state_nx = S_RW_W;
            end
            S_RW_W:   if (tm_done) state_nx = S_PRE;
            S_PRE: begin
                tm_load  = 1'b1;
                tm_val   = TW'(PRE_GAP - 2);
                state_nx = S_PRE_W;
            end
            S_PRE_W:  if (tm_done) state_nx = S_IDLE;
            S_RPRE: begin
                tm_load  = 1'b1;
                tm_val   = TW'(T_RP - 2);
                state_nx = S_RPRE_W;
            end
            S_RPRE_W: if (tm_done) state_nx = S_REF;
            S_REF: begin
                ref_ack  = 1'b1;
                tm_load  = 1'b1;
                tm_val   = TW'(T_RC - 2);
                state_nx = S_REF_W;
            end
            S_REF_W:  if (tm_done) state_nx = S_IDLE;
            default:  state_nx = S_PAUSE;
        endcase
    end

    // command pins, address and data enable
    always_comb begin
        cmd      = CMD_NOP;
        sd_ba    = '0;
        sd_a     = '0;
        sd_dq_oe = 1'b0;
        unique case (state)
            S_IPRE, S_PRE, S_RPRE: begin
                cmd          = CMD_PRE;
                sd_a[AP_BIT] = 1'b1;
            end
            S_IREF, S_REF: cmd = CMD_REF;
            S_IMRS: begin
                cmd  = CMD_MRS;
                sd_a = MODE_WORD;
            end
            S_ACT: begin
                cmd   = CMD_ACT;
                sd_ba = bank_q;
                sd_a  = row_q;
            end
            S_RW: begin
                cmd      = we_q ? CMD_WR : CMD_RD;
                sd_ba    = bank_q;
                sd_a     = ROW_W'(col_q);
                sd_dq_oe = we_q;
            end
            default: cmd = CMD_NOP;
        endcase
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
    assign sd_dq_out = wdata_q;
    assign issue_rd  = (state == S_RW) && !we_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_cnt   <= '0;
            init_done <= 1'b0;
        end else begin
            if (state == S_IREF) ref_cnt <= ref_cnt + 1'b1;
            if (state == S_IMRS_W && tm_done) init_done <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            we_q    <= host_we;
            addr_q  <= host_addr;
            wdata_q <= host_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_pipe     <= '0;
            host_rvalid <= 1'b0;
            host_rdata  <= '0;
        end else begin
            rd_pipe     <= {rd_pipe[CAS_LAT-2:0], issue_rd};
            host_rvalid <= rd_pipe[CAS_LAT-1];
            if (rd_pipe[CAS_LAT-1]) host_rdata <= sd_dq_in;
        end
    end

endmodule

// File: rtl/sdram_ctl_sva.sv
module sdram_ctl_sva #(
    parameter int ROW_W   = 11,
    parameter int BANK_W  = 1,
    parameter int CAS_LAT = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [BANK_W-1:0] sd_ba,
    input logic [ROW_W-1:0]  sd_a,
    input logic              sd_dq_oe,
    input logic              host_req,
    input logic              host_ready,
    input logic              host_rvalid
);

    wire [3:0] c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    // R3
    p_mrs_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (c == 4'b0000) |-> (sd_ba == '0 && sd_a == ROW_W'((1 << 9) | (CAS_LAT << 4))));

    // R4
    p_act_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (c == 4'b0011) |=> (c == 4'b0111));

    // R5
    p_rvalid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |=> !host_rvalid);

    // R8
    p_accept_act_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_ready) |=> (c == 4'b0011));

    // R9
    p_oe_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dq_oe == (c == 4'b0100));

    // R10
    p_legal_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        c inside {4'b0111, 4'b0011, 4'b0101, 4'b0100, 4'b0010, 4'b0001, 4'b0000});

    // R10
    p_pre_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (c == 4'b0010) |-> sd_a[10]);

endmodule

bind sdram_ctl sdram_ctl_sva #(
    .ROW_W   (ROW_W),
    .BANK_W  (BANK_W),
    .CAS_LAT (CAS_LAT)
) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .sd_cs_n     (sd_cs_n),
    .sd_ras_n    (sd_ras_n),
    .sd_cas_n    (sd_cas_n),
    .sd_we_n     (sd_we_n),
    .sd_ba       (sd_ba),
    .sd_a        (sd_a),
    .sd_dq_oe    (sd_dq_oe),
    .host_req    (host_req),
    .host_ready  (host_ready),
    .host_rvalid (host_rvalid)
);

// File: tb/sdram_ctl_bench.sv
module sdram_ctl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int P_PAUSE    = 120;
    localparam int P_REFI     = 400;
    localparam int CAS        = 3;
    localparam int TRCD = 5, TRP = 5, TRAS = 9, TRC = 13, TWR = 5, TMRD = 2;
    localparam int SLACK      = 40;

    logic        clk, rst_n;
    logic        host_req, host_we;
    logic [19:0] host_addr;
    logic [15:0] host_wdata, host_rdata;
    logic        host_ready, host_rvalid;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [0:0]  sd_ba;
    logic [10:0] sd_a;
    logic [15:0] sd_dq_in, sd_dq_out;
    logic        sd_dq_oe;

    sdram_ctl #(
        .INIT_PAUSE   (P_PAUSE),
        .REF_INTERVAL (P_REFI)
    ) u_sdram_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_req    (host_req),
        .host_we     (host_we),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .host_ready  (host_ready),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid),
        .sd_cs_n     (sd_cs_n),
        .sd_ras_n    (sd_ras_n),
        .sd_cas_n    (sd_cas_n),
        .sd_we_n     (sd_we_n),
        .sd_ba       (sd_ba),
        .sd_a        (sd_a),
        .sd_dq_in    (sd_dq_in),
        .sd_dq_out   (sd_dq_out),
        .sd_dq_oe    (sd_dq_oe)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int vectors = 0;
    int miscompares = 0;
    bit done_flag = 0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    // model and reference state
    int cyc_e;
    int last_act[2], last_wr[2], open_row[2];
    bit open_b[2];
    int last_pre = -1000, last_ref = -1000, last_mrs = -1000;
    int init_step = 0, mrs_time = 0, last_nref = 0, nref_count = 0;
    int due_q[$], rv_cyc_q[$];
    logic [15:0] dat_q[$], exp_q[$];
    logic [15:0] dram[int];
    logic [15:0] shadow[int];
    logic        cur_we;
    logic [19:0] cur_addr;
    logic [15:0] cur_wdata;

    initial begin
        for (int b = 0; b < 2; b++) begin
            last_act[b] = -1000; last_wr[b] = -1000; open_b[b] = 0; open_row[b] = 0;
        end
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc_e <= 0;
        else        cyc_e <= cyc_e + 1;
    end

    // behavioural SDRAM model and per-cycle comparison
    always @(negedge clk) begin
        if (rst_n) begin
            logic [3:0] c;
            bit in_init;
            int n, b, key;
            c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            n = cyc_e;
            b = int'(sd_ba);
            in_init = (init_step < 10);

            chk(sd_dq_oe == (c == 4'b0100), "R9", "oe vs WRITE", sd_dq_oe, c == 4'b0100);
            if (in_init) chk(!host_ready, "R2", "ready during start-up", host_ready, 0);
            if (n < P_PAUSE) chk(c == 4'b0111, "R1", "command in pause", c, 4'b0111);

            if (c != 4'b0111) begin
                chk(c inside {4'b0011, 4'b0101, 4'b0100, 4'b0010, 4'b0001, 4'b0000},
                    "R10", "command code", c, 4'b0111);
                chk(n - last_mrs >= TMRD, "R4", "mode to cmd gap", n - last_mrs, TMRD);
                if (in_init) begin
                    logic [3:0] e;
                    e = (init_step == 0) ? 4'b0010 : (init_step <= 8) ? 4'b0001 : 4'b0000;
                    chk(c == e, "R2", "start-up order", c, e);
                    init_step++;
                end
                case (c)
                    4'b0011: begin
                        chk(!in_init, "R2", "ACTIVE before start-up done", 1, 0);
                        chk(!open_b[b], "R10", "ACTIVE to open bank", 1, 0);
                        chk(sd_ba == cur_addr[19], "R7", "ACTIVE bank", sd_ba, cur_addr[19]);
                        chk(sd_a == cur_addr[18:8], "R7", "ACTIVE row", sd_a, cur_addr[18:8]);
                        chk(n - last_pre >= TRP, "R4", "PRE to ACT", n - last_pre, TRP);
                        chk(n - last_ref >= TRC, "R4", "REF to ACT", n - last_ref, TRC);
                        chk(n - last_act[b] >= TRC, "R4", "ACT to ACT", n - last_act[b], TRC);
                        open_b[b] = 1; open_row[b] = int'(sd_a); last_act[b] = n;
                    end
                    4'b0101, 4'b0100: begin
                        chk(open_b[b], "R10", "access to closed bank", 0, 1);
                        chk(n - last_act[b] >= TRCD, "R4", "ACT to RD/WR", n - last_act[b], TRCD);
                        chk(sd_a[7:0] == cur_addr[7:0] && !sd_a[10], "R7", "column",
                            sd_a, cur_addr[7:0]);
                        chk((c == 4'b0100) == cur_we, "R8", "access direction", c, cur_we);
                        key = int'({sd_ba, open_row[b][10:0], sd_a[7:0]});
                        if (c == 4'b0100) begin
                            chk(sd_dq_out == cur_wdata, "R9", "write data", sd_dq_out, cur_wdata);
                            dram[key] = sd_dq_out;
                            last_wr[b] = n;
                        end else begin
                            due_q.push_back(n + CAS);
                            dat_q.push_back(dram.exists(key) ? dram[key] : 16'hDEAD);
                            rv_cyc_q.push_back(n + CAS + 1);
                        end
                    end
                    4'b0010: begin
                        chk(sd_a[10], "R10", "precharge all", sd_a[10], 1);
                        for (int k = 0; k < 2; k++) begin
                            if (open_b[k]) begin
                                chk(n - last_act[k] >= TRAS, "R4", "ACT to PRE", n - last_act[k], TRAS);
                                chk(n - last_wr[k] >= TWR, "R4", "WR to PRE", n - last_wr[k], TWR);
                            end
                            open_b[k] = 0;
                        end
                        last_pre = n;
                    end
                    4'b0001: begin
                        chk(!open_b[0] && !open_b[1], "R6", "REF with open bank",
                            {open_b[1], open_b[0]}, 0);
                        chk(n - last_pre >= TRP, "R4", "PRE to REF", n - last_pre, TRP);
                        chk(n - last_ref >= TRC, "R4", "REF to REF", n - last_ref, TRC);
                        if (!in_init) begin
                            int gap;
                            gap = n - ((nref_count == 0) ? mrs_time : last_nref);
                            chk(gap >= P_REFI - SLACK && gap <= P_REFI + SLACK, "R6",
                                "refresh gap", gap, P_REFI);
                            last_nref = n; nref_count++;
                        end
                        last_ref = n;
                    end
                    4'b0000: begin
                        chk(sd_ba == 1'b0 && sd_a == 11'h230, "R3", "mode word",
                            {sd_ba, sd_a}, 12'h230);
                        chk(n - last_ref >= TRC, "R4", "REF to MODE", n - last_ref, TRC);
                        chk(n - last_pre >= TRP, "R4", "PRE to MODE", n - last_pre, TRP);
                        chk(n >= P_PAUSE, "R1", "pause length", n, P_PAUSE);
                        last_mrs = n; mrs_time = n;
                    end
                    default: ;
                endcase
            end

            if (due_q.size() > 0 && due_q[0] == n) begin
                void'(due_q.pop_front());
                sd_dq_in = dat_q.pop_front();
            end else begin
                sd_dq_in = 16'h0BAD;
            end

            if (host_rvalid) begin
                if (rv_cyc_q.size() == 0 || exp_q.size() == 0) begin
                    chk(0, "R5", "unexpected rvalid", 1, 0);
                end else begin
                    int ec;
                    logic [15:0] ed;
                    ec = rv_cyc_q.pop_front();
                    ed = exp_q.pop_front();
                    chk(n == ec, "R5", "read latency", n, ec);
                    chk(host_rdata == ed, "R5", "read data", host_rdata, ed);
                end
            end
        end
    end

    task automatic access(bit we, logic [19:0] addr, logic [15:0] d);
        @(negedge clk);
        host_req = 1; host_we = we; host_addr = addr; host_wdata = d;
        while (!host_ready) @(negedge clk);
        cur_we = we; cur_addr = addr; cur_wdata = d;
        if (we) shadow[int'(addr)] = d;
        else    exp_q.push_back(shadow.exists(int'(addr)) ? shadow[int'(addr)] : 16'hDEAD);
        @(negedge clk);
        host_req = 0;
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0011, "R8", "ACTIVE after accept",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0011);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "R1", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        logic [19:0] alist[$];
        logic [19:0] lfsr;
        rst_n = 0; host_req = 0; host_we = 0; host_addr = '0; host_wdata = '0;
        sd_dq_in = 16'h0BAD;
        repeat (4) @(negedge clk);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1", "reset command",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
        chk(!host_ready && !host_rvalid && !sd_dq_oe, "R1", "reset outputs",
            {host_ready, host_rvalid, sd_dq_oe}, 0);
        rst_n = 1;
        while (!host_ready) @(negedge clk);
        chk(init_step == 10, "R2", "start-up steps before ready", init_step, 10);

        alist.push_back(20'h00000);
        alist.push_back(20'hFFFFF);
        alist.push_back(20'h80000);
        alist.push_back(20'h7FFFF);
        alist.push_back(20'h000FF);
        alist.push_back(20'h80100);
        lfsr = 20'h1ACE5;
        for (int i = 0; i < 40; i++) begin
            lfsr = {lfsr[18:0], lfsr[19] ^ lfsr[16]};
            alist.push_back(lfsr);
        end
        foreach (alist[i]) access(1, alist[i], alist[i][15:0] ^ 16'h5A5A ^ 16'(i));
        foreach (alist[i]) access(0, alist[i], 16'h0);
        for (int i = 0; i < 6; i++) begin
            access(1, alist[i], 16'hC000 | 16'(i * 7));
            access(0, alist[i], 16'h0);
        end
        repeat (1500) @(negedge clk);
        access(0, 20'hFFFFF, 16'h0);
        access(0, 20'h00000, 16'h0);
        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R5", "reads left unanswered", exp_q.size(), 0);
        chk(nref_count >= (cyc_e - mrs_time) / P_REFI - 1, "R6", "refresh count",
            nref_count, (cyc_e - mrs_time) / P_REFI - 1);
        chk(!open_b[0] && !open_b[1], "R10", "banks closed at idle", {open_b[1], open_b[0]}, 0);
        finish_run();
    end

endmodule